// File: doc/BRIEF.md
# Audio Effect DSP Multiply-Accumulate Step Core

This block is the arithmetic heart of one step of a microprogrammed sound-effect processor. For each step it takes decoded control bits, an input operand, a temporary-memory word and a 16-bit coefficient. From these it picks a 24-bit X, a 13-bit Y and a 26-bit addend B. It forms the signed product of X and Y, shifts it right arithmetically by 12 and adds B to give the next accumulator value. A shifter turns the current accumulator into a 24-bit result, either by saturating or by wrapping.

The shifter result and the input operand also load three holding registers: a Y register, a fraction register and an address register. These registers feed later steps. Instruction fetch and every memory stay outside the block. The sequencer pulses `step_en` once per executed step and pulses `frame_clr` at the start of each sample frame.

Top module: `mac_step_core`

## Requirements
- R1: After reset `acc_q`, `frac_q`, `addr_q` and `yreg_q` are zero. No register changes in a cycle where `step_en` and `frame_clr` are both low.
- R2: On a step, `acc_q` becomes ((X·Y) >>> 12) + B. The product is signed, X and Y are two's complement, and the sum wraps to 26 bits.
- R3: B is zero when `b_zero`=1. Otherwise B is the previous `acc_q` when `b_from_acc`=1, or `tmp_word` sign-extended from bit 23 when `b_from_acc`=0. A nonzero-path B is negated when `b_neg`=1.
- R4: X is `in_opnd` when `x_from_in`=1 and `tmp_word` when `x_from_in`=0.
- R5: `y_src` selects the 13-bit Y. The value 0 selects `frac_q`. The value 1 selects `coef_word[15:3]`. The value 2 selects `yreg_q[23:11]`. The value 3 selects `yreg_q[15:4]` with a zero above it. Y is then sign-extended from its bit 12.
- R6: `shift_out` is combinational from the current `acc_q`. With `shift_mode`=0 it is `acc_q`, and with `shift_mode`=1 it is 2·`acc_q`. Both saturate to the range 0x800000 (most negative) to 0x7FFFFF.
- R7: With `shift_mode`=2, `shift_out` is 2·`acc_q` truncated to 24 bits. With `shift_mode`=3 it is `acc_q` truncated to 24 bits.
- R8: On a step with `frac_load`=1, `frac_q` loads `{0, shift_out[11:0]}` when `shift_mode`=3, and `shift_out[23:11]` otherwise. The value used is `shift_out` before the step.
- R9: On a step with `addr_load`=1, `addr_q` loads `shift_out[23:12]` when `shift_mode`=3. Otherwise it loads `in_opnd[23:16]` sign-extended to 12 bits.
- R10: On a step with `yreg_load`=1, `yreg_q` loads `in_opnd`. Y selection in that same step uses the old `yreg_q`.
- R11: `frame_clr` zeroes `acc_q`, `frac_q`, `addr_q` and `yreg_q` on the next edge, and it overrides `step_en`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| step_en | input | 1 | Execute one step on this edge |
| frame_clr | input | 1 | Synchronous clear of all registers |
| x_from_in | input | 1 | X source: 1 input operand, 0 temp word |
| y_src | input | 2 | Y source select (see R5) |
| b_zero | input | 1 | Force B to zero |
| b_from_acc | input | 1 | B source: 1 accumulator, 0 temp word |
| b_neg | input | 1 | Negate B |
| shift_mode | input | 2 | Shifter mode (see R6, R7) |
| frac_load | input | 1 | Load fraction register |
| addr_load | input | 1 | Load address register |
| yreg_load | input | 1 | Load Y register from input operand |
| in_opnd | input | 24 | Input operand |
| tmp_word | input | 24 | Temporary-memory operand |
| coef_word | input | 16 | Coefficient |
| acc_q | output | 26 | Accumulator |
| shift_out | output | 24 | Shifter result |
| frac_q | output | 13 | Fraction register |
| addr_q | output | 12 | Address register |
| yreg_q | output | 24 | Y holding register |

## Verification
Every internal register of this block is also a port, so a wrong accumulator shows up on `acc_q` one edge after the step that produced it. A fault in X, Y or B selection therefore appears after a single step. A wrong slice in the holding registers shows up on the same edge in `frac_q`, `addr_q` or `yreg_q`. It then spreads into the accumulator of the next step that selects that register as Y. The shifter is combinational, so a saturation or wrap error is visible on `shift_out` as soon as the mode changes, with no step needed.

// File: rtl/mac_pkg.sv
package mac_pkg;
  localparam int DAT_W      = 24;
  localparam int ACC_W      = 26;
  localparam int Y_W        = 13;
  localparam int COEF_W     = 16;
  localparam int ADDR_W     = 12;
  localparam int PROD_SHIFT = 12;
  localparam int YMID_LSB   = 4;
  localparam int ADDR_IN_LSB = 16;
  localparam int PROD_W     = DAT_W + Y_W;

  localparam logic signed [ACC_W:0] SAT_HI = (ACC_W+1)'((1 << (DAT_W-1)) - 1);
  localparam logic signed [ACC_W:0] SAT_LO = ~SAT_HI;

  typedef enum logic [1:0] {YS_FRAC, YS_COEF, YS_YHI, YS_YMID} ysrc_e;
  typedef enum logic [1:0] {SH_SAT1, SH_SAT2, SH_WRAP2, SH_WRAP1} shmode_e;

  typedef struct packed {
    logic    x_from_in;
    ysrc_e   y_src;
    logic    b_zero;
    logic    b_from_acc;
    logic    b_neg;
    shmode_e shift_mode;
    logic    frac_load;
    logic    addr_load;
    logic    yreg_load;
  } ctrl_t;

  // clamp a widened accumulator value into the data range
  function automatic logic [DAT_W-1:0] clamp_dat(input logic signed [ACC_W:0] v);
    if (v > SAT_HI)      return {1'b0, {(DAT_W-1){1'b1}}};
    else if (v < SAT_LO) return {1'b1, {(DAT_W-1){1'b0}}};
    else                 return v[DAT_W-1:0];
  endfunction

  // signed product scaled down by PROD_SHIFT, fitted to the accumulator
  function automatic logic signed [ACC_W-1:0] scaled_product(
      input logic signed [DAT_W-1:0] x, input logic signed [Y_W-1:0] y);
    logic signed [PROD_W-1:0] p;
    logic signed [PROD_W-1:0] ps;
    p  = PROD_W'(x) * PROD_W'(y);
    ps = p >>> PROD_SHIFT;
    return ps[ACC_W-1:0];
  endfunction

  function automatic logic signed [ACC_W-1:0] sext_dat(input logic [DAT_W-1:0] d);
    return {{(ACC_W-DAT_W){d[DAT_W-1]}}, d};
  endfunction
endpackage

// File: rtl/mac_operand_sel.sv
module mac_operand_sel
  import mac_pkg::*;
(
  input  ctrl_t                    ctrl,
  input  logic [DAT_W-1:0]         in_opnd,
  input  logic [DAT_W-1:0]         tmp_word,
  input  logic [COEF_W-1:0]        coef_word,
  input  logic signed [ACC_W-1:0]  acc_q,
  input  logic [Y_W-1:0]           frac_q,
  input  logic [DAT_W-1:0]         yreg_q,
  output logic signed [DAT_W-1:0]  x_val,
  output logic signed [Y_W-1:0]    y_val,
  output logic signed [ACC_W-1:0]  b_val
);
  logic signed [ACC_W-1:0] b_raw;

  assign x_val = ctrl.x_from_in ? in_opnd : tmp_word;

  always_comb begin
    unique case (ctrl.y_src)
      YS_FRAC: y_val = frac_q;
      YS_COEF: y_val = coef_word[COEF_W-1:COEF_W-Y_W];
      YS_YHI:  y_val = yreg_q[DAT_W-1:DAT_W-Y_W];
      default: y_val = {1'b0, yreg_q[YMID_LSB+Y_W-2:YMID_LSB]};
    endcase
  end

  always_comb begin
    b_raw = ctrl.b_from_acc ? acc_q : sext_dat(tmp_word);
    if (ctrl.b_zero)     b_val = '0;
    else if (ctrl.b_neg) b_val = -b_raw;
    else                 b_val = b_raw;
  end
endmodule

// File: rtl/mac_shifter.sv
module mac_shifter
  import mac_pkg::*;
(
  input  shmode_e                 mode,
  input  logic signed [ACC_W-1:0] acc_q,
  output logic [DAT_W-1:0]        shift_out
);
  logic signed [ACC_W:0] acc_wide;
  logic signed [ACC_W:0] acc_dbl;

  assign acc_wide = {acc_q[ACC_W-1], acc_q};
  assign acc_dbl  = {acc_q, 1'b0};

  always_comb begin
    unique case (mode)
      SH_SAT1:  shift_out = clamp_dat(acc_wide);
      SH_SAT2:  shift_out = clamp_dat(acc_dbl);
      SH_WRAP2: shift_out = acc_dbl[DAT_W-1:0];
      default:  shift_out = acc_q[DAT_W-1:0];
    endcase
  end
endmodule

// File: rtl/mac_hold_regs.sv
module mac_hold_regs
  import mac_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              step_en,
  input  logic              frame_clr,
  input  ctrl_t             ctrl,
  input  logic [DAT_W-1:0]  shift_out,
  input  logic [DAT_W-1:0]  in_opnd,
  output logic [Y_W-1:0]    frac_q,
  output logic [ADDR_W-1:0] addr_q,
  output logic [DAT_W-1:0]  yreg_q
);
  localparam int AIN_W = DAT_W - ADDR_IN_LSB;

  logic [Y_W-1:0]    frac_nxt;
  logic [ADDR_W-1:0] addr_nxt;
  logic              wrap1;

  assign wrap1 = (ctrl.shift_mode == SH_WRAP1);

  assign frac_nxt = wrap1 ? {1'b0, shift_out[Y_W-2:0]}
                          : shift_out[DAT_W-1:DAT_W-Y_W];
  assign addr_nxt = wrap1 ? shift_out[DAT_W-1:DAT_W-ADDR_W]
                          : {{(ADDR_W-AIN_W){in_opnd[DAT_W-1]}}, in_opnd[DAT_W-1:ADDR_IN_LSB]};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      frac_q <= '0;
      addr_q <= '0;
      yreg_q <= '0;
    end else if (frame_clr) begin
      frac_q <= '0;
      addr_q <= '0;
      yreg_q <= '0;
    end else if (step_en) begin
      if (ctrl.frac_load) frac_q <= frac_nxt;
      if (ctrl.addr_load) addr_q <= addr_nxt;
      if (ctrl.yreg_load) yreg_q <= in_opnd;
    end
  end

  p_frac_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (!frame_clr && !(step_en && ctrl.frac_load)) |=> $stable(frac_q));
  p_addr_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (!frame_clr && !(step_en && ctrl.addr_load)) |=> $stable(addr_q));
  p_yreg_load_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (step_en && ctrl.yreg_load && !frame_clr) |=> (yreg_q == $past(in_opnd)));
endmodule

// File: rtl/mac_step_core.sv
module mac_step_core
  import mac_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              step_en,
  input  logic              frame_clr,
  input  logic              x_from_in,
  input  logic [1:0]        y_src,
  input  logic              b_zero,
  input  logic              b_from_acc,
  input  logic              b_neg,
  input  logic [1:0]        shift_mode,
  input  logic              frac_load,
  input  logic              addr_load,
  input  logic              yreg_load,
  input  logic [23:0]       in_opnd,
  input  logic [23:0]       tmp_word,
  input  logic [15:0]       coef_word,
  output logic [25:0]       acc_q,
  output logic [23:0]       shift_out,
  output logic [12:0]       frac_q,
  output logic [11:0]       addr_q,
  output logic [23:0]       yreg_q
);
  ctrl_t                   ctrl;
  logic signed [DAT_W-1:0] x_val;
  logic signed [Y_W-1:0]   y_val;
  logic signed [ACC_W-1:0] b_val;
  logic signed [ACC_W-1:0] acc_nxt;
  logic signed [ACC_W-1:0] acc_r;
  logic                    step_fire;

  assign ctrl.x_from_in  = x_from_in;
  assign ctrl.y_src      = ysrc_e'(y_src);
  assign ctrl.b_zero     = b_zero;
  assign ctrl.b_from_acc = b_from_acc;
  assign ctrl.b_neg      = b_neg;
  assign ctrl.shift_mode = shmode_e'(shift_mode);
  assign ctrl.frac_load  = frac_load;
  assign ctrl.addr_load  = addr_load;
  assign ctrl.yreg_load  = yreg_load;

  assign step_fire = step_en && !frame_clr;

  mac_operand_sel u_sel (
    .ctrl(ctrl), .in_opnd(in_opnd), .tmp_word(tmp_word), .coef_word(coef_word),
    .acc_q(acc_r), .frac_q(frac_q), .yreg_q(yreg_q),
    .x_val(x_val), .y_val(y_val), .b_val(b_val)
  );

  mac_shifter u_shf (
    .mode(ctrl.shift_mode), .acc_q(acc_r), .shift_out(shift_out)
  );

  mac_hold_regs u_hold (
    .clk(clk), .rst_n(rst_n), .step_en(step_en), .frame_clr(frame_clr),
    .ctrl(ctrl), .shift_out(shift_out), .in_opnd(in_opnd),
    .frac_q(frac_q), .addr_q(addr_q), .yreg_q(yreg_q)
  );

  assign acc_nxt = scaled_product(x_val, y_val) + b_val;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)         acc_r <= '0;
    else if (frame_clr) acc_r <= '0;
    else if (step_en)   acc_r <= acc_nxt;
  end

  assign acc_q = acc_r;

  p_acc_hold_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (!step_en && !frame_clr) |=> $stable(acc_r));
  p_zero_terms_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (step_fire && b_zero && x_val == '0) |=> (acc_r == '0));
  p_clear_all_r11: assert property (@(posedge clk) disable iff (!rst_n)
    frame_clr |=> (acc_r == '0 && frac_q == '0 && addr_q == '0 && yreg_q == '0));
  p_sat_hi_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (shift_mode == 2'd0 && !acc_r[ACC_W-1] && (|acc_r[ACC_W-2:DAT_W-1]))
      |-> (shift_out == {1'b0, {(DAT_W-1){1'b1}}}));
  p_sat_lo_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (shift_mode == 2'd0 && acc_r[ACC_W-1] && !(&acc_r[ACC_W-2:DAT_W-1]))
      |-> (shift_out == {1'b1, {(DAT_W-1){1'b0}}}));
endmodule

// File: tb/test_mac_step_core.sv
`timescale 1ns/1ps
module test_mac_step_core;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic step_en = 0, frame_clr = 0, x_from_in = 0, b_zero = 0, b_from_acc = 0, b_neg = 0;
  logic frac_load = 0, addr_load = 0, yreg_load = 0;
  logic [1:0] y_src = 0, shift_mode = 0;
  logic [23:0] in_opnd = 0, tmp_word = 0;
  logic [15:0] coef_word = 0;
  logic [25:0] acc_q;
  logic [23:0] shift_out, yreg_q;
  logic [12:0] frac_q;
  logic [11:0] addr_q;

  int checks = 0;
  int failures = 0;
  bit done = 0;

  longint m_acc = 0, m_frac = 0, m_addr = 0, m_yreg = 0;

  always #4 clk = ~clk;

  mac_step_core i_mac_step_core (.*);

  function automatic longint sx(longint v, int w);
    return (v <<< (64 - w)) >>> (64 - w);
  endfunction

  function automatic longint mdl_shift(longint a, int mode);
    longint v;
    v = (mode == 1 || mode == 2) ? a * 2 : a;
    if (mode < 2) begin
      if (v > 64'sh7FFFFF) v = 64'sh7FFFFF;
      if (v < -64'sh800000) v = -64'sh800000;
    end
    return v & 64'hFFFFFF;
  endfunction

  task automatic chk(string req, string what, longint act, longint exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  task automatic chk_all(string req);
    chk(req, "acc", longint'(acc_q), m_acc & 64'h3FFFFFF);
    chk(req, "frac", longint'(frac_q), m_frac);
    chk(req, "addr", longint'(addr_q), m_addr);
    chk(req, "yreg", longint'(yreg_q), m_yreg);
  endtask

  task automatic step(string req, bit xs, int ys, bit bz, bit ba, bit bn, int sm,
                      bit fl, bit al, bit yl, logic [23:0] inp, logic [23:0] tmp, logic [15:0] cf);
    longint xv, yraw, yv, bv, sh, nacc;
    @(negedge clk);
    x_from_in = xs; y_src = 2'(ys); b_zero = bz; b_from_acc = ba; b_neg = bn;
    shift_mode = 2'(sm); frac_load = fl; addr_load = al; yreg_load = yl;
    in_opnd = inp; tmp_word = tmp; coef_word = cf; step_en = 1'b1;
    xv = xs ? sx(longint'(inp), 24) : sx(longint'(tmp), 24);
    case (ys)
      0: yraw = m_frac;
      1: yraw = longint'(cf) >> 3;
      2: yraw = (m_yreg >> 11) & 64'h1FFF;
      default: yraw = (m_yreg >> 4) & 64'hFFF;
    endcase
    yv = sx(yraw, 13);
    if (bz) bv = 0;
    else begin
      bv = ba ? m_acc : sx(longint'(tmp), 24);
      if (bn) bv = -bv;
    end
    sh = mdl_shift(m_acc, sm);
    nacc = sx(((xv * yv) >>> 12) + bv, 26);
    if (fl) m_frac = (sm == 3) ? (sh & 64'hFFF) : ((sh >> 11) & 64'h1FFF);
    if (al) m_addr = (sm == 3) ? ((sh >> 12) & 64'hFFF) : ((sx(longint'(inp), 24) >>> 16) & 64'hFFF);
    if (yl) m_yreg = longint'(inp);
    m_acc = nacc;
    @(negedge clk);
    step_en = 1'b0; frac_load = 0; addr_load = 0; yreg_load = 0;
    chk_all(req);
  endtask

  task automatic look_shift(string req, int sm);
    @(negedge clk);
    shift_mode = 2'(sm);
    #1;
    chk(req, $sformatf("shift mode %0d", sm), longint'(shift_out), mdl_shift(m_acc, sm));
  endtask

  task automatic t_reset();
    chk_all("R1");
    chk("R1", "shift_out reset", longint'(shift_out), 0);
  endtask

  task automatic t_mac_basic();
    step("R2 R4 R5", 1, 1, 1, 0, 0, 0, 0, 0, 0, 24'h400000, 24'h0, 16'h8000);
    step("R2 R4", 0, 1, 1, 0, 0, 0, 0, 0, 0, 24'h7FFFFF, 24'h200000, 16'h4000);
    step("R2 R4 wrap", 1, 1, 1, 0, 0, 0, 0, 0, 0, 24'hC00001, 24'h0, 16'h7FF8);
  endtask

  task automatic t_bsel();
    step("R3 acc neg", 1, 1, 0, 1, 1, 0, 0, 0, 0, 24'h123456, 24'h0, 16'h0);
    step("R3 tmp", 1, 1, 0, 0, 0, 0, 0, 0, 0, 24'h0, 24'hFFFFF0, 16'h0);
    step("R3 tmp neg", 0, 1, 0, 0, 1, 0, 0, 0, 0, 24'h0, 24'hFFFFF0, 16'h0);
    step("R3 zero", 0, 1, 1, 1, 1, 0, 0, 0, 0, 24'h0, 24'h333333, 16'h0);
  endtask

  task automatic t_shift();
    step("R6 build hi", 1, 1, 0, 0, 0, 0, 0, 0, 0, 24'h7FFFFF, 24'h7FFFFF, 16'h7FF8);
    for (int m = 0; m < 4; m++) look_shift(m < 2 ? "R6 hi" : "R7 hi", m);
    step("R6 build lo", 1, 1, 0, 0, 1, 0, 0, 0, 0, 24'h800000, 24'h7FFFFF, 16'h7FF8);
    for (int m = 0; m < 4; m++) look_shift(m < 2 ? "R6 lo" : "R7 lo", m);
    step("R6 build mid", 1, 1, 0, 0, 0, 0, 0, 0, 0, 24'h0, 24'h500000, 16'h0);
    for (int m = 0; m < 4; m++) look_shift(m < 2 ? "R6 mid" : "R7 mid", m);
  endtask

  task automatic t_frac_addr();
    step("R8 R9 setup", 1, 1, 0, 0, 0, 0, 0, 0, 0, 24'h0, 24'h123456, 16'h0);
    step("R8 R9 mode3", 1, 1, 0, 1, 0, 3, 1, 1, 0, 24'h0, 24'h0, 16'h0);
    step("R8 R9 mode0", 1, 1, 0, 1, 0, 0, 1, 1, 0, 24'h9A0000, 24'h0, 16'h0);
    step("R8 R9 mode2", 1, 1, 0, 1, 0, 2, 1, 1, 0, 24'h3B0000, 24'h0, 16'h0);
    step("R5 frac src", 1, 0, 1, 0, 0, 0, 0, 0, 0, 24'h100000, 24'h0, 16'h0);
  endtask

  task automatic t_yreg();
    step("R10 old y", 1, 2, 1, 0, 0, 0, 0, 0, 1, 24'h5A5A5A, 24'h0, 16'h0);
    step("R10 R5 y hi", 1, 2, 1, 0, 0, 0, 0, 0, 0, 24'h100000, 24'h0, 16'h0);
    step("R5 y mid", 1, 3, 1, 0, 0, 0, 0, 0, 0, 24'h100000, 24'h0, 16'h0);
    step("R10 load ones", 1, 1, 1, 0, 0, 0, 0, 0, 1, 24'hFFFFFF, 24'h0, 16'h0);
    step("R5 y hi signext", 1, 2, 1, 0, 0, 0, 0, 0, 0, 24'h200000, 24'h0, 16'h0);
    step("R5 y mid no signext", 1, 3, 1, 0, 0, 0, 0, 0, 0, 24'h200000, 24'h0, 16'h0);
  endtask

  task automatic t_hold();
    @(negedge clk);
    x_from_in = 1; y_src = 1; b_zero = 0; b_from_acc = 1; b_neg = 1; shift_mode = 0;
    frac_load = 1; addr_load = 1; yreg_load = 1;
    in_opnd = 24'hABCDEF; tmp_word = 24'h654321; coef_word = 16'h7777;
    repeat (4) @(negedge clk);
    chk_all("R1 hold");
    frac_load = 0; addr_load = 0; yreg_load = 0;
  endtask

  task automatic t_clear();
    @(negedge clk);
    frame_clr = 1; step_en = 1; frac_load = 1; yreg_load = 1;
    @(negedge clk);
    frame_clr = 0; step_en = 0; frac_load = 0; yreg_load = 0;
    m_acc = 0; m_frac = 0; m_addr = 0; m_yreg = 0;
    chk_all("R11");
  endtask

  initial begin
    #(8 * 100000);
    if (!done) begin
      failures++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_mac_basic();
    t_bsel();
    t_shift();
    t_frac_addr();
    t_yreg();
    t_hold();
    t_clear();
    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule